// File: doc/BRIEF.md
# ECP Command Byte Decoder

This block sits between two byte queues on the host side of an extended-capability parallel channel and the logic that drives the channel. One queue holds command bytes and the other holds data bytes. The decoder merges the two into a single output stream. Each output beat carries a byte and a flag that marks it as a channel address or as data.

A command byte with its most significant bit set becomes one address beat. Its low seven bits form the address, and the top bit of the emitted byte is zero. A command byte with that bit clear produces no output. It records a run-length code N, and the next data byte is then sent N+1 times in a row. A data byte that arrives with no code pending is sent once.

All three streams use a valid/ready handshake. A data byte stays at the head of its queue while its copies go out, and it is popped in the cycle the last copy is taken. Command bytes have priority over data whenever no run is in progress. A producer that wants a code to apply to a particular byte must therefore present the code first.

Top module: `ecp_cmd_decoder`

## Requirements
- R1: A command byte with bit 7 = 1 produces exactly one output beat with out_is_addr = 1 and out_byte = {0, command[6:0]}.
- R2: A command byte with bit 7 = 0 produces no output beat on its own.
- R3: A code N (bit 7 = 0, N = bits 6..0) makes the next data byte appear N+1 times with out_is_addr = 0, so 00h gives one copy and 7Fh gives 128 copies.
- R4: A code is used up by the single data byte that follows it. The data byte after that is sent once.
- R5: With no code pending, every data byte is sent exactly once.
- R6: While out_valid is high and out_ready is low, out_valid, out_byte and out_is_addr hold. No copy is lost or repeated under backpressure.
- R7: data_ready is high only in the cycle in which the last copy of the current data byte is accepted at the output.
- R8: A second code that arrives before any data byte replaces the first one.
- R9: When neither an address beat nor a run is in progress, a valid command byte is taken before a valid data byte. While a run or an address beat is in progress, cmd_ready is low.
- R10: An address command taken between a code and its data byte leaves the pending code unchanged.
- R11: After reset, out_valid is low and no code is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Command byte taken this cycle when valid |
| cmd_byte | input | 8 | Command byte: bit 7 = 1 address, bit 7 = 0 run-length code |
| data_valid | input | 1 | Data byte present |
| data_ready | output | 1 | Data byte popped this cycle (last copy accepted) |
| data_byte | input | 8 | Data byte |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Output beat accepted |
| out_byte | output | 8 | Output byte |
| out_is_addr | output | 1 | 1 = address beat, 0 = data beat |

## Verification
A code register that is stale or never cleared shows up on the next data byte as extra or missing copies. A copy counter that is off by one gives one copy too many or too few, and pops the data queue early or late. A run lock that is lost lets an address beat cut into a run, so the out-of-order beat appears at the very next accepted output. Each of these faults is visible in the order and count of output beats by the time the run in question ends, and random backpressure keeps the hold behaviour under test throughout.

// File: rtl/ecp_cmd_pkg.sv
package ecp_cmd_pkg;
  typedef enum logic [1:0] {
    CK_NONE  = 2'd0,
    CK_ADDR  = 2'd1,
    CK_COUNT = 2'd2
  } cmd_kind_e;
endpackage

// File: rtl/ecp_rst_sync.sv
module ecp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ecp_cmd_classify.sv
module ecp_cmd_classify
  import ecp_cmd_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CODE_W = BYTE_W - 1
) (
  input  logic              valid,
  input  logic [BYTE_W-1:0] cmd,
  output cmd_kind_e         kind,
  output logic [CODE_W-1:0] payload
);
  always_comb begin
    if (!valid)             kind = CK_NONE;
    else if (cmd[BYTE_W-1]) kind = CK_ADDR;
    else                    kind = CK_COUNT;
  end

  assign payload = cmd[CODE_W-1:0];
endmodule

// File: rtl/ecp_addr_slot.sv
module ecp_addr_slot #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CODE_W-1:0] load_val,
  input  logic              ack,
  output logic              pend,
  output logic [CODE_W-1:0] addr
);
  logic pend_q, pend_d;
  logic [CODE_W-1:0] addr_q;

  always_comb begin
    pend_d = pend_q;
    if (load_en)  pend_d = 1'b1;
    else if (ack) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (load_en) addr_q <= load_val;
  end

  assign pend = pend_q;
  assign addr = addr_q;
endmodule

// File: rtl/ecp_run_tracker.sv
module ecp_run_tracker #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CODE_W-1:0] load_val,
  input  logic              copy_fire,
  output logic              last_copy
);
  logic [CODE_W-1:0] code_q;
  logic              code_vld_q, code_vld_d;
  logic [CODE_W-1:0] cpy_q, cpy_d;
  logic [CODE_W-1:0] limit;

  assign limit     = code_vld_q ? code_q : '0;
  assign last_copy = (cpy_q == limit);

  always_comb begin
    code_vld_d = code_vld_q;
    cpy_d      = cpy_q;
    if (copy_fire) begin
      if (last_copy) begin
        cpy_d      = '0;
        code_vld_d = 1'b0;
      end else begin
        cpy_d = cpy_q + 1'b1;
      end
    end
    if (load_en) code_vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (load_en) code_q <= load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_vld_q <= 1'b0;
      cpy_q      <= '0;
    end else begin
      code_vld_q <= code_vld_d;
      cpy_q      <= cpy_d;
    end
  end
endmodule

// File: rtl/ecp_cmd_decoder.sv
module ecp_cmd_decoder
  import ecp_cmd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic              data_valid,
  output logic              data_ready,
  input  logic [BYTE_W-1:0] data_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_is_addr
);
  localparam int CODE_W = BYTE_W - 1;

  logic              rst_ni;
  cmd_kind_e         kind;
  logic [CODE_W-1:0] payload;
  logic              cmd_fire, addr_load, code_load;
  logic              addr_pend;
  logic [CODE_W-1:0] addr_val;
  logic              show, last_copy, copy_fire;
  logic              lock_q, lock_d;

  ecp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  ecp_cmd_classify #(.BYTE_W(BYTE_W)) u_cls (
    .valid(cmd_valid), .cmd(cmd_byte), .kind(kind), .payload(payload)
  );

  assign cmd_ready = ~addr_pend & ~lock_q;
  assign cmd_fire  = cmd_valid & cmd_ready;
  assign addr_load = cmd_fire & (kind == CK_ADDR);
  assign code_load = cmd_fire & (kind == CK_COUNT);

  ecp_addr_slot #(.CODE_W(CODE_W)) u_addr (
    .clk(clk), .rst_n(rst_ni), .load_en(addr_load), .load_val(payload),
    .ack(out_ready), .pend(addr_pend), .addr(addr_val)
  );

  assign show      = ~addr_pend & data_valid & (lock_q | ~cmd_valid);
  assign copy_fire = show & out_ready;

  ecp_run_tracker #(.CODE_W(CODE_W)) u_run (
    .clk(clk), .rst_n(rst_ni), .load_en(code_load), .load_val(payload),
    .copy_fire(copy_fire), .last_copy(last_copy)
  );

  assign lock_d = show & ~(out_ready & last_copy);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else         lock_q <= lock_d;
  end

  assign data_ready  = copy_fire & last_copy;
  assign out_valid   = addr_pend | show;
  assign out_is_addr = addr_pend;
  assign out_byte    = addr_pend ? {1'b0, addr_val} : data_byte;
endmodule

// File: rtl/ecp_cmd_decoder_chk.sv
module ecp_cmd_decoder_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              data_valid,
  input logic              data_ready,
  input logic [BYTE_W-1:0] data_byte,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_byte,
  input logic              out_is_addr
);
  AST_ADDR_MSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_addr |-> !out_byte[BYTE_W-1]); // R1

  AST_DATA_FROM_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_addr |-> data_valid && out_byte == data_byte); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_is_addr)); // R6

  AST_POP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> out_valid && out_ready && !out_is_addr); // R7

  AST_ADDR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_addr |-> !cmd_ready && !data_ready); // R9

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready && data_valid && data_ready)); // R9
endmodule

bind ecp_cmd_decoder ecp_cmd_decoder_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .data_valid(data_valid), .data_ready(data_ready), .data_byte(data_byte),
  .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
  .out_is_addr(out_is_addr)
);

// File: tb/ecp_cmd_decoder_test.sv
module ecp_cmd_decoder_test;
  logic clk, rst_n;
  logic cmd_valid, cmd_ready, data_valid, data_ready;
  logic [7:0] cmd_byte, data_byte, out_byte;
  logic out_valid, out_ready, out_is_addr;

  int n_chk, n_bad;
  bit bp_on, done;
  int model_code;
  bit model_vld;

  typedef struct {
    logic       is_addr;
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  ecp_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte),
    .data_valid(data_valid), .data_ready(data_ready), .data_byte(data_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_is_addr(out_is_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expectation model
  task automatic model_cmd(logic [7:0] b, string tag);
    exp_t e;
    if (b[7]) begin                       // R1 address beat; R10 code kept
      e.is_addr = 1'b1; e.val = {1'b0, b[6:0]}; e.tag = tag;
      exp_q.push_back(e);
    end else begin                        // R2 no beat; R8 replaces
      model_code = b[6:0]; model_vld = 1'b1;
    end
  endtask

  task automatic model_data(logic [7:0] b, string tag);
    int n;
    exp_t e;
    n = model_vld ? model_code + 1 : 1;   // R3 / R5
    model_vld = 1'b0;                     // R4
    for (int i = 0; i < n; i++) begin
      e.is_addr = 1'b0; e.val = b; e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic drive_cmd(logic [7:0] b);
    @(negedge clk);
    cmd_byte = b; cmd_valid = 1'b1;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic drive_data(logic [7:0] b);
    @(negedge clk);
    data_byte = b; data_valid = 1'b1;
    #2;
    while (!data_ready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    data_valid = 1'b0;
  endtask

  task automatic send_cmd(logic [7:0] b, string tag);
    model_cmd(b, tag); drive_cmd(b);
  endtask

  task automatic send_data(logic [7:0] b, string tag);
    model_data(b, tag); drive_data(b);
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 5000) begin @(negedge clk); t++; end
    check(exp_q.size() == 0, "R3 drain", exp_q.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      out_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected beat", {out_is_addr, out_byte}, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_is_addr == e.is_addr && out_byte == e.val, e.tag,
                {out_is_addr, out_byte}, {e.is_addr, e.val});
        end
      end
    end
  end

  initial begin
    #400000;
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; bp_on = 1'b0; model_vld = 1'b0; model_code = 0;
    cmd_valid = 1'b0; data_valid = 1'b0; cmd_byte = '0; data_byte = '0;
    out_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 check(out_valid == 1'b0, "R11 reset out_valid", out_valid, 0);
    check(data_ready == 1'b0, "R11 reset data_ready", data_ready, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R11 and R5: no code pending after reset
    send_data(8'hA1, "R11 single after reset");
    send_data(8'hA2, "R5 single");
    send_data(8'hA3, "R5 single");
    // R1
    send_cmd(8'h92, "R1 address");
    // R3 code 00h gives one copy
    send_cmd(8'h00, "R2 code");
    send_data(8'h5A, "R3 code 0");
    // R4 code consumed by one byte
    send_cmd(8'h04, "R2 code");
    send_data(8'h11, "R3 code 4");
    send_data(8'h22, "R4 follow-up once");
    // R8 replacement
    send_cmd(8'h05, "R2 code");
    send_cmd(8'h01, "R8 code");
    send_data(8'h33, "R8 replaced code");
    // R10 address between code and data
    send_cmd(8'h02, "R2 code");
    send_cmd(8'h9A, "R10 address");
    send_data(8'h44, "R10 code kept");
    drain();

    // R6 backpressure, R3 maximum run
    bp_on = 1'b1;
    send_cmd(8'h7F, "R2 code");
    send_data(8'hC7, "R3 code 7F");
    send_cmd(8'h03, "R2 code");
    send_data(8'h0F, "R6 run under backpressure");
    send_cmd(8'hFF, "R6 address under backpressure");
    send_data(8'hE1, "R6 single under backpressure");
    drain();
    bp_on = 1'b0;

    // R9 command taken before data
    model_cmd(8'h03, "R9 code first");
    model_data(8'hB6, "R9 data after code");
    fork
      drive_cmd(8'h03);
      drive_data(8'hB6);
      begin
        @(negedge clk); #1;
        check(cmd_ready == 1'b1, "R9 cmd_ready when idle", cmd_ready, 1);
        check(out_valid == 1'b0, "R9 data held back", out_valid, 0);
      end
    join
    drain();

    // R9 command waits during a run; R7 pop on last copy
    model_cmd(8'h02, "R9 code");
    model_data(8'h3C, "R9 run not interrupted");
    model_cmd(8'h85, "R9 address after run");
    drive_cmd(8'h02);
    fork
      drive_data(8'h3C);
      begin @(negedge clk); drive_cmd(8'h85); end
      begin
        @(negedge clk); #2;
        check(data_ready == 1'b0, "R7 no pop on first copy", data_ready, 0);
        @(negedge clk); #1;
        check(cmd_ready == 1'b0, "R9 cmd_ready low in run", cmd_ready, 0);
        @(negedge clk); #2;
        check(data_ready == 1'b1, "R7 pop on last copy", data_ready, 1);
      end
    join
    drain();

    repeat (5) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule